// File: doc/BRIEF.md
# Packed Colour Palette Store

This block holds the colour lookup table of an LCD controller. It has 256 entries. Software writes the table as 128 words of 32 bits, and each word carries two 16-bit colour codes. A single bus write therefore fills two neighbouring entries in one step. Each code holds three 5-bit channels. The block widens each channel to 8 bits by appending three zero bits, and keeps the result as a 24-bit RGB value.

The pixel pipeline presents an 8-bit pixel value on the lookup port and receives the expanded colour one cycle later. Alongside the expanded table, the block keeps every written word unchanged. A bus read therefore gives back exactly what software stored, including bits the colour path discards.

Top module: `palette_ram`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stored word and every expanded entry is cleared, and `lut_rgb` and `bus_rdata` become zero.
- R2: A write of word n (`bus_we` high, `bus_idx` = n) sets entry 2n from `bus_wdata[15:0]`.
- R3: The same write sets entry 2n+1 from `bus_wdata[31:16]`.
- R4: Within a 16-bit code, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. `lut_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R5: Bit 15 of each code has no effect on the expanded colour.
- R6: Each output channel equals its 5-bit field shifted left by three, so bits [2:0] of every channel are zero.
- R7: `bus_rdata` returns, one cycle after `bus_idx` is presented, the full 32-bit word last written at that index. A read in the same cycle as a write to that index returns the previous word.
- R8: `lut_rgb` shows the entry selected by `lut_idx` one clock after the index is presented.
- R9: When a write and a lookup of one of its two entries fall in the same cycle, the lookup returns the value held before the write.
- R10: A write of word n leaves every entry other than 2n and 2n+1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the word at `bus_idx` |
| bus_idx | input | 7 | Word index for bus write and read |
| bus_wdata | input | 32 | Word to store (two packed colour codes) |
| bus_rdata | output | 32 | Registered readback of the stored word |
| lut_idx | input | 8 | Pixel value selecting a palette entry |
| lut_rgb | output | 24 | Registered expanded colour, red/green/blue high to low |

## Verification
The vectors include codes that light a single channel, so that a design which swaps red and blue, or mixes up the two halves of a word, puts colour into the wrong byte. Codes with bit 15 set are expected to expand the same as codes with it clear, while the readback must still return that bit; a design that drops the raw copy, or lets the intensity bit into a channel, fails one of these two checks. A write that collides with a lookup of the same entry catches write-through forwarding. Checks on the first and last words, and on entries left untouched, catch index decoding that is off by one bit or that writes more than two entries.

// File: rtl/palette_pkg.sv
// Package: shared sizes and the colour-code expansion used by the palette store.
// Assumes a 16-bit code with three 5-bit channels and an unused top bit.
package palette_pkg;
    localparam int WORDS    = 128;
    localparam int CODE_W   = 16;
    localparam int CH_IN_W  = 5;
    localparam int CH_OUT_W = 8;
    localparam int WORD_W   = 2 * CODE_W;
    localparam int ENTRIES  = 2 * WORDS;
    localparam int RGB_W    = 3 * CH_OUT_W;
    localparam int WIDX_W   = $clog2(WORDS);
    localparam int EIDX_W   = $clog2(ENTRIES);

    // Widen one 5-bit channel by appending zero bits.
    function automatic logic [CH_OUT_W-1:0] widen(input logic [CH_IN_W-1:0] ch);
        return {ch, {(CH_OUT_W-CH_IN_W){1'b0}}};
    endfunction
endpackage

// File: rtl/palette_unpack.sv
// Module: splits one 32-bit bus word into two expanded RGB entries.
// Assumes the low half feeds the even entry and the high half the odd entry.
// Pure combinational; the top bit of each code is dropped.
module palette_unpack
    import palette_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output logic [RGB_W-1:0]  rgb_lo,
    output logic [RGB_W-1:0]  rgb_hi
);
    logic [RGB_W-1:0] rgb_pair [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [CODE_W-1:0] code;
        assign code = word_in[h*CODE_W +: CODE_W];
        // Reorder fields: red is lowest in the code, highest in the output.
        assign rgb_pair[h] = {widen(code[0*CH_IN_W +: CH_IN_W]),
                              widen(code[1*CH_IN_W +: CH_IN_W]),
                              widen(code[2*CH_IN_W +: CH_IN_W])};
    end

    assign rgb_lo = rgb_pair[0];
    assign rgb_hi = rgb_pair[1];
endmodule

// File: rtl/palette_raw_store.sv
// Module: keeps each bus word exactly as written and returns it on read.
// Assumes one shared index for write and read; read is registered and
// returns the value held before a same-cycle write.
module palette_raw_store
    import palette_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [WORDS];

    // Store the word on write; clear all words in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Register the readback of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[idx];
    end
endmodule

// File: rtl/palette_rgb_store.sv
// Module: holds the expanded colour entries and serves the pixel lookup.
// Assumes a write fills an even/odd entry pair; the lookup is registered
// and sees the pre-write contents on a same-cycle collision.
module palette_rgb_store
    import palette_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [RGB_W-1:0]  rgb_lo,
    input  logic [RGB_W-1:0]  rgb_hi,
    input  logic [EIDX_W-1:0] ridx,
    output logic [RGB_W-1:0]  rgb_out
);
    logic [RGB_W-1:0] ent [ENTRIES];

    // Write both entries of the pair; clear every entry in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else if (we) begin
            ent[{widx, 1'b0}] <= rgb_lo;
            ent[{widx, 1'b1}] <= rgb_hi;
        end
    end

    // Register the looked-up colour.
    always_ff @(posedge clk) begin
        if (!rst_n) rgb_out <= '0;
        else        rgb_out <= ent[ridx];
    end
endmodule

// File: rtl/palette_ram.sv
// Module: top of the packed palette store. Routes a bus write to both the raw
// word store and, after expansion, to the RGB entry store.
// Assumes synchronous active-low reset and a single clock domain.
module palette_ram
    import palette_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [WIDX_W-1:0] bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [EIDX_W-1:0] lut_idx,
    output logic [RGB_W-1:0]  lut_rgb
);
    logic [RGB_W-1:0] exp_lo;
    logic [RGB_W-1:0] exp_hi;

    palette_unpack u_unpack (
        .word_in (bus_wdata),
        .rgb_lo  (exp_lo),
        .rgb_hi  (exp_hi)
    );

    palette_raw_store u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .idx   (bus_idx),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );

    palette_rgb_store u_rgb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .widx    (bus_idx),
        .rgb_lo  (exp_lo),
        .rgb_hi  (exp_hi),
        .ridx    (lut_idx),
        .rgb_out (lut_rgb)
    );
endmodule

// File: rtl/palette_ram_chk.sv
// Checker: timing and format properties of palette_ram, bound to every instance.
module palette_ram_chk
    import palette_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [WIDX_W-1:0] bus_idx,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [EIDX_W-1:0] lut_idx,
    input logic [RGB_W-1:0]  lut_rgb
);
    logic seen  = 1'b0;
    logic rst_q = 1'b1;

    // Track whether a previous edge exists and what reset was there.
    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        rst_q <= rst_n;
    end

    // R1: outputs are zero after a reset edge.
    always_ff @(posedge clk) begin
        if (seen && !rst_q) begin
            p_reset_clears_r1: assert (lut_rgb == '0 && bus_rdata == '0);
        end
    end

    // R6: the three low bits of every output channel stay zero.
    p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_rgb[2:0] == 3'b0 && lut_rgb[10:8] == 3'b0 && lut_rgb[18:16] == 3'b0));

    // R7: a word written and then read back returns unchanged.
    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we ##1 (!bus_we && $stable(bus_idx))) |=> (bus_rdata == $past(bus_wdata, 2)));

    // R2: the even entry of a written word expands its low half.
    p_even_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we ##1 (lut_idx == {$past(bus_idx), 1'b0})) |=>
        (lut_rgb == {$past(bus_wdata[4:0], 2), 3'b0,
                     $past(bus_wdata[9:5], 2), 3'b0,
                     $past(bus_wdata[14:10], 2), 3'b0}));

    // R8: with no write and a steady index, the lookup output holds.
    p_lookup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we ##1 (!bus_we && $stable(lut_idx))) |=> $stable(lut_rgb));
endmodule

bind palette_ram palette_ram_chk chk_i (.*);

// File: tb/palette_ram_tb_top.sv
module palette_ram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    // Stimulus table: word index, written word, expected even / odd entry.
    localparam logic [6:0]  V_IDX [NVEC] = '{7'd0, 7'd5, 7'd10, 7'd127, 7'd64};
    localparam logic [31:0] V_DAT [NVEC] = '{32'hFFFF_FFFF, 32'h0000_001F,
                                            32'h03E0_7C00, 32'h8001_0421, 32'h1234_5678};
    localparam logic [23:0] V_LO  [NVEC] = '{24'hF8F8F8, 24'hF80000,
                                            24'h0000F8, 24'h080808, 24'hC098A8};
    localparam logic [23:0] V_HI  [NVEC] = '{24'hF8F8F8, 24'h000000,
                                            24'h00F800, 24'h080000, 24'hA08820};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_ram dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [6:0] idx, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_idx = idx; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic lookup(input logic [7:0] idx, output logic [23:0] rgb);
        @(negedge clk);
        lut_idx = idx;
        @(negedge clk);
        rgb = lut_rgb;
    endtask

    task automatic read_word(input logic [6:0] idx, output logic [31:0] w);
        @(negedge clk);
        bus_idx = idx;
        @(negedge clk);
        w = bus_rdata;
    endtask

    initial begin
        logic [23:0] rgb;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        check("R1 lut_rgb in reset", {8'h0, lut_rgb}, 32'h0);
        check("R1 bus_rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        lookup(8'd255, rgb);
        check("R1 entry 255 after reset", {8'h0, rgb}, 32'h0);
        read_word(7'd127, w);
        check("R1 word 127 after reset", w, 32'h0);

        // Table walk: R2 even entry, R3 odd entry, R4/R5/R6 format, R7 readback
        for (int v = 0; v < NVEC; v++) begin
            write_word(V_IDX[v], V_DAT[v]);
            lookup({V_IDX[v], 1'b0}, rgb);
            check("R2 R4 R6 even entry", {8'h0, rgb}, {8'h0, V_LO[v]});
            lookup({V_IDX[v], 1'b1}, rgb);
            check("R3 R4 R5 odd entry", {8'h0, rgb}, {8'h0, V_HI[v]});
            read_word(V_IDX[v], w);
            check("R7 raw readback", w, V_DAT[v]);
        end

        // R5: bit 15 alone in both halves gives black but reads back intact
        write_word(7'd33, 32'h8000_8000);
        lookup(8'd66, rgb);
        check("R5 intensity bit even", {8'h0, rgb}, 32'h0);
        lookup(8'd67, rgb);
        check("R5 intensity bit odd", {8'h0, rgb}, 32'h0);
        read_word(7'd33, w);
        check("R7 intensity bit kept", w, 32'h8000_8000);

        // R10: neighbours of written words stay untouched
        lookup(8'd2, rgb);
        check("R10 entry 2 untouched", {8'h0, rgb}, 32'h0);
        lookup(8'd9, rgb);
        check("R10 entry 9 untouched", {8'h0, rgb}, 32'h0);
        lookup(8'd12, rgb);
        check("R10 entry 12 untouched", {8'h0, rgb}, 32'h0);
        lookup(8'd0, rgb);
        check("R10 entry 0 kept", {8'h0, rgb}, 32'h00F8F8F8);

        // R8: output follows a new index after exactly one clock
        @(negedge clk);
        lut_idx = 8'd128;
        check("R8 before edge", {8'h0, lut_rgb}, 32'h00F8F8F8);
        @(negedge clk);
        check("R8 after one edge", {8'h0, lut_rgb}, 32'h00C098A8);

        // R9 and R7: collision of write with lookup and read of same entry
        @(negedge clk);
        bus_we = 1'b1; bus_idx = 7'd20; bus_wdata = 32'h001F_001F; lut_idx = 8'd40;
        @(negedge clk);
        bus_we = 1'b0;
        check("R9 collision returns old entry", {8'h0, lut_rgb}, 32'h0);
        check("R7 collision returns old word", bus_rdata, 32'h0);
        @(negedge clk);
        check("R9 new entry next cycle", {8'h0, lut_rgb}, 32'h00F80000);
        check("R7 new word next cycle", bus_rdata, 32'h001F_001F);

        // R1: reset after writes clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(8'd40, rgb);
        check("R1 entry cleared by reset", {8'h0, rgb}, 32'h0);
        read_word(7'd10, w);
        check("R1 word cleared by reset", w, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule